// File: doc/BRIEF.md
# Host Command Interrupt Register

This block is an 8-bit command register through which an external host forces a processor core to take an interrupt at a vector the host chooses. With one byte write the host picks one of 128 vector numbers in the low seven bits and raises a command request in the top bit. The core sees a pending flag and a gated interrupt request. It also sees a registered vector address equal to twice the vector number.

When the core acknowledges the interrupt, the hardware clears the command bit. The host reads the register back and polls that bit as its completion handshake. While a command is outstanding, host writes are discarded. This protects the vector that the core is about to use. The block has no link to any data transfer path.

Top module: `host_cmd_irq`

## Requirements
- R1: After a synchronous reset the read-back byte is 0x32 (command bit 0, vector 0x32), the pending flag and the request are 0, and the vector address is 0x64.
- R2: A host write whose bit 7 is 0, accepted while no command is pending, loads bits 6..0 into the vector field. The read-back shows the new byte from the next cycle on, and no command becomes pending.
- R3: A host write whose bit 7 is 1, accepted while no command is pending, sets the command bit and the pending flag from the next cycle on. The vector written in that same cycle is the one used.
- R4: The vector address output is 8 bits wide and always equals the vector field shifted left by one: vector 0 gives 0x00 and vector 127 gives 0xFE.
- R5: The core request equals the pending flag ANDed with the core enable input. The pending flag does not depend on the enable.
- R6: An acknowledge while a command is pending clears the command bit and the pending flag in the next cycle. The vector field is left unchanged.
- R7: A host write while a command is pending changes neither the vector nor the command bit.
- R8: A host write in the same cycle as an acknowledge is dropped, and the acknowledge's clear takes effect.
- R9: While the request is asserted, the vector address output stays stable.
- R10: An acknowledge while no command is pending leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, shared by every reset source |
| host_wr | input | 1 | Host write strobe for the command register |
| host_wdata | input | 8 | Host write byte: bit 7 is the command bit, bits 6..0 are the vector |
| host_rdata | output | 8 | Read-back byte: command bit and vector field |
| core_irq_en | input | 1 | Core-side enable for the interrupt request |
| core_ack | input | 1 | Core acknowledge of the host command interrupt |
| core_pend | output | 1 | Host command pending flag |
| core_irq | output | 1 | Interrupt request to the core |
| core_vec_addr | output | 8 | Interrupt address, twice the vector number |

## Verification
A host write and a core acknowledge can fall in the same clock cycle. This is the race between a host issuing its next command and the core accepting the current one. The bench provokes it by driving both strobes in one row of its vector table while a command is pending, and again while none is pending. It judges the result from the read-back byte, the pending flag and the vector address in the following cycle: the written byte must not appear, and the command bit must be clear.

// File: rtl/hcir_pkg.sv
package hcir_pkg;
  localparam int VEC_W  = 7;
  localparam int BYTE_W = VEC_W + 1;
  localparam int ADDR_W = VEC_W + 1;
  localparam logic [VEC_W-1:0] VEC_RESET = 7'h32;

  typedef struct packed {
    logic             cmd;
    logic [VEC_W-1:0] vec;
  } cmd_reg_t;
endpackage

// File: rtl/hcir_cmd_reg.sv
module hcir_cmd_reg
  import hcir_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter logic [VW-1:0] RV = VEC_RESET,
  localparam int BW = VW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [BW-1:0] wdata,
  input  logic          ack,
  output logic          cmd,
  output logic [VW-1:0] vec,
  output logic          load
);
  logic cmd_q;
  logic [VW-1:0] vec_q;

  // a write lands only when nothing is outstanding and no acknowledge arrives
  assign load = wr && !cmd_q && !ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= 1'b0;
      vec_q <= RV;
    end else if (ack && cmd_q) begin
      cmd_q <= 1'b0;
    end else if (load) begin
      cmd_q <= wdata[BW-1];
      vec_q <= wdata[VW-1:0];
    end
  end

  assign cmd = cmd_q;
  assign vec = vec_q;
endmodule

// File: rtl/hcir_core_if.sv
module hcir_core_if
  import hcir_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter logic [VW-1:0] RV = VEC_RESET,
  localparam int AW = VW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [VW-1:0] new_vec,
  input  logic          pend,
  input  logic          en,
  output logic          irq,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= {RV, 1'b0};
    else if (load) addr_q <= {new_vec, 1'b0};
  end

  assign addr = addr_q;
  assign irq  = pend & en;
endmodule

// File: rtl/host_cmd_irq.sv
module host_cmd_irq
  import hcir_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter logic [VW-1:0] RV = VEC_RESET,
  localparam int BW = VW + 1,
  localparam int AW = VW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic [BW-1:0] host_wdata,
  output logic [BW-1:0] host_rdata,
  input  logic          core_irq_en,
  input  logic          core_ack,
  output logic          core_pend,
  output logic          core_irq,
  output logic [AW-1:0] core_vec_addr
);
  logic          cmd_w;
  logic [VW-1:0] vec_w;
  logic          load_w;

  hcir_cmd_reg #(.VW(VW), .RV(RV)) u_reg (
    .clk(clk), .rst(rst), .wr(host_wr), .wdata(host_wdata), .ack(core_ack),
    .cmd(cmd_w), .vec(vec_w), .load(load_w)
  );

  hcir_core_if #(.VW(VW), .RV(RV)) u_core (
    .clk(clk), .rst(rst), .load(load_w), .new_vec(host_wdata[VW-1:0]),
    .pend(cmd_w), .en(core_irq_en), .irq(core_irq), .addr(core_vec_addr)
  );

  assign host_rdata = {cmd_w, vec_w};
  assign core_pend  = cmd_w;
endmodule

// File: rtl/host_cmd_irq_chk.sv
module host_cmd_irq_chk #(
  parameter int BW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          host_wr,
  input logic [BW-1:0] host_wdata,
  input logic [BW-1:0] host_rdata,
  input logic          core_irq_en,
  input logic          core_ack,
  input logic          core_pend,
  input logic          core_irq,
  input logic [AW-1:0] core_vec_addr
);
  AST_RESET_STATE: assert property (@(posedge clk) $fell(rst) |-> (host_rdata == 8'h32 && !core_pend && core_vec_addr == 8'h64)); // R1
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst) (host_wr && !core_pend && !core_ack) |=> host_rdata == $past(host_wdata)); // R2
  AST_CMD_SETS_PEND: assert property (@(posedge clk) disable iff (rst) (host_wr && host_wdata[BW-1] && !core_pend && !core_ack) |=> core_pend); // R3
  AST_ADDR_TRACK: assert property (@(posedge clk) disable iff (rst) core_vec_addr == {host_rdata[BW-2:0], 1'b0}); // R4
  AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst) core_irq |-> (core_pend && core_irq_en)); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst) (core_pend && core_ack) |=> (!core_pend && $stable(host_rdata[BW-2:0]))); // R6
  AST_WR_IGNORED: assert property (@(posedge clk) disable iff (rst) (core_pend && !core_ack) |=> $stable(host_rdata)); // R7
  AST_COLLIDE_DROP: assert property (@(posedge clk) disable iff (rst) (host_wr && core_ack) |=> ($stable(host_rdata[BW-2:0]) && !core_pend)); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst) core_irq |=> $stable(core_vec_addr)); // R9
  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (rst) (!core_pend && core_ack) |=> $stable(host_rdata)); // R10
endmodule

bind host_cmd_irq host_cmd_irq_chk #(.BW(BW), .AW(AW)) u_chk (.*);

// File: tb/host_cmd_irq_test.sv
module host_cmd_irq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       core_irq_en = 1'b0;
  logic       core_ack = 1'b0;
  logic       core_pend;
  logic       core_irq;
  logic [7:0] core_vec_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  host_cmd_irq uut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .core_irq_en(core_irq_en), .core_ack(core_ack),
    .core_pend(core_pend), .core_irq(core_irq), .core_vec_addr(core_vec_addr)
  );

  // row: {tag, wr, wdata, ack, en, exp_rdata, exp_pend, exp_irq, exp_addr}
  localparam int NROW = 13;
  localparam logic [32:0] TBL [NROW] = '{
    {4'd2,  1'b1, 8'h15, 1'b0, 1'b1, 8'h15, 1'b0, 1'b0, 8'h2A}, // R2 plain vector write
    {4'd3,  1'b1, 8'h85, 1'b0, 1'b1, 8'h85, 1'b1, 1'b1, 8'h0A}, // R3 command + vector together
    {4'd7,  1'b1, 8'h11, 1'b0, 1'b1, 8'h85, 1'b1, 1'b1, 8'h0A}, // R7 write while pending
    {4'd5,  1'b0, 8'h00, 1'b0, 1'b0, 8'h85, 1'b1, 1'b0, 8'h0A}, // R5 enable low masks request
    {4'd9,  1'b0, 8'h00, 1'b0, 1'b1, 8'h85, 1'b1, 1'b1, 8'h0A}, // R9 address held
    {4'd8,  1'b1, 8'h22, 1'b1, 1'b1, 8'h05, 1'b0, 1'b0, 8'h0A}, // R8 ack beats write
    {4'd10, 1'b0, 8'h00, 1'b1, 1'b1, 8'h05, 1'b0, 1'b0, 8'h0A}, // R10 idle ack
    {4'd4,  1'b1, 8'hFF, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b1, 8'hFE}, // R4 top vector
    {4'd6,  1'b0, 8'h00, 1'b1, 1'b1, 8'h7F, 1'b0, 1'b0, 8'hFE}, // R6 ack clears
    {4'd4,  1'b1, 8'h80, 1'b0, 1'b0, 8'h80, 1'b1, 1'b0, 8'h00}, // R4 vector zero
    {4'd6,  1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00}, // R6 ack with enable low
    {4'd8,  1'b1, 8'h9C, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00}, // R8 write with idle ack dropped
    {4'd2,  1'b1, 8'h7F, 1'b0, 1'b1, 8'h7F, 1'b0, 1'b0, 8'hFE}  // R2 write after clear
  };

  task automatic check(input int tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_reset(input string when);
    check(1, {"R1 rdata ", when}, host_rdata, 8'h32);
    check(1, {"R1 pend ", when}, {7'd0, core_pend}, 8'h00);
    check(1, {"R1 irq ", when}, {7'd0, core_irq}, 8'h00);
    check(1, {"R1 addr ", when}, core_vec_addr, 8'h64);
  endtask

  initial begin
    core_irq_en = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset("initial");

    for (int i = 0; i < NROW; i++) begin
      logic [32:0] r;
      r = TBL[i];
      host_wr     = r[28];
      host_wdata  = r[27:20];
      core_ack    = r[19];
      core_irq_en = r[18];
      @(posedge clk);
      #2;
      host_wr  = 1'b0;
      core_ack = 1'b0;
      check(int'(r[32:29]), "rdata", host_rdata, r[17:10]);
      check(int'(r[32:29]), "pend", {7'd0, r[9]}, {7'd0, core_pend});
      check(int'(r[32:29]), "irq", {7'd0, core_irq}, {7'd0, r[8]});
      check(int'(r[32:29]), "addr", core_vec_addr, r[7:0]);
      @(negedge clk);
    end

    // R1: reset while a command is pending
    host_wr = 1'b1; host_wdata = 8'h9A; core_irq_en = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    check(3, "pend before reset", {7'd0, core_pend}, 8'h01);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_reset("after mid-command reset");

    // R5: pending flag unaffected by toggling enable
    host_wr = 1'b1; host_wdata = 8'hC0; core_irq_en = 1'b0;
    @(negedge clk);
    host_wr = 1'b0;
    check(5, "pend with enable low", {7'd0, core_pend}, 8'h01);
    check(5, "irq with enable low", {7'd0, core_irq}, 8'h00);
    core_irq_en = 1'b1;
    #1;
    check(5, "irq after enable", {7'd0, core_irq}, 8'h01);
    check(4, "addr for vector 0x40", core_vec_addr, 8'h80);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule